// File: doc/BRIEF.md
# Posted Write Buffer

This block sits between a cache and main memory. It holds processor stores in a small first-in, first-out queue and sends them to memory in the background. The processor hands over a store in a single cycle and carries on. Meanwhile the buffer sends its oldest pending store to memory. Each store is offered once through a request/acknowledge handshake, and stores leave in the order they arrived.

The processor is held back only when every slot is occupied. A store that is still waiting in the queue cannot be read back. A lookup port reports whether an address has a pending store, so a read to that address can be delayed until the store has reached memory. An empty flag and an occupancy count are also provided.

Top module: `post_wr_buf`

## Requirements
- R1: Reset is active low and asynchronous. It empties the buffer: `count_o` is 0, `empty_o` is 1, and `mem_req_o` and `cpu_stall_o` are 0.
- R2: When the buffer is not full, a store presented with `cpu_valid_i` is taken in that cycle with `cpu_stall_o` low, and the count rises by one after the clock edge.
- R3: Stores reach the memory port in the same order in which they were accepted from the processor.
- R4: `mem_req_o` is high whenever the buffer holds at least one entry. `mem_addr_o` and `mem_data_o` carry the oldest entry and stay unchanged until `mem_ack_i` is seen.
- R5: An entry is removed only in a cycle where `mem_req_o` and `mem_ack_i` are both high. At most one entry is removed per cycle.
- R6: When the buffer is full and no acknowledge arrives, a presented store raises `cpu_stall_o` and is not stored. The count stays at the depth.
- R7: When the buffer is full and an acknowledge arrives in the same cycle, a presented store is accepted without a stall. It takes the freed slot and the count stays at the depth.
- R8: `look_hit_o` is high exactly when `look_addr_i` equals the address of an entry held in the buffer. A store being presented in the same cycle is not yet held. The hit clears once the last matching entry has been acknowledged.
- R9: `count_o` gives the number of held entries, from 0 to DEPTH (default 8), and `empty_o` is high exactly when the count is 0.
- R10: An accepted store and a removal in the same cycle leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_valid_i | input | 1 | Processor presents a store |
| cpu_addr_i | input | AW | Store address |
| cpu_data_i | input | DW | Store data |
| cpu_stall_o | output | 1 | Store not taken; processor must hold it |
| mem_req_o | output | 1 | Oldest entry offered to memory |
| mem_addr_o | output | AW | Address of the oldest entry |
| mem_data_o | output | DW | Data of the oldest entry |
| mem_ack_i | input | 1 | Memory has taken the offered entry |
| look_addr_i | input | AW | Address to test for a pending store |
| look_hit_o | output | 1 | A held entry matches `look_addr_i` |
| empty_o | output | 1 | Buffer holds nothing |
| count_o | output | $clog2(DEPTH+1) | Number of held entries |

## Verification
A processor store and a memory acknowledge can occur in the same cycle. This case matters most when the buffer is full, because the acknowledge then decides whether the store stalls. The bench fills all eight slots, holds a store in the stall state for several cycles, and then raises the acknowledge while the store is still presented. It expects the stall to drop in that cycle, the count to stay at eight, and the new store to come out last after the earlier entries. The table-driven part also overlaps a store with a removal below full and expects the count to stay the same.

// File: rtl/wb_pkg.sv
package wb_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_POP  = 2'b01,
    OP_PUSH = 2'b10,
    OP_BOTH = 2'b11
  } wb_op_e;
endpackage

// File: rtl/wb_ctrl.sv
module wb_ctrl #(
  parameter int DEPTH = 8,
  parameter int PW    = 3,
  parameter int CW    = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cpu_valid_i,
  input  logic          mem_ack_i,
  output logic          push_o,
  output logic          pop_o,
  output logic [PW-1:0] wr_ptr_o,
  output logic [PW-1:0] rd_ptr_o,
  output logic [CW-1:0] count_o,
  output logic          empty_o,
  output logic          stall_o
);
  import wb_pkg::*;

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          full;
  wb_op_e        op;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == FULL_CNT);
  assign empty_o = (cnt_q == '0);
  assign pop_o   = !empty_o && mem_ack_i;
  // a same-cycle retire frees a slot for the incoming store
  assign push_o  = cpu_valid_i && (!full || pop_o);
  assign stall_o = cpu_valid_i && full && !pop_o;
  assign op      = wb_op_e'({push_o, pop_o});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_o) wr_q <= ptr_next(wr_q);
      if (pop_o)  rd_q <= ptr_next(rd_q);
      case (op)
        OP_PUSH: cnt_q <= cnt_q + 1'b1;
        OP_POP:  cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign wr_ptr_o = wr_q;
  assign rd_ptr_o = rd_q;
  assign count_o  = cnt_q;

  // R9
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL_CNT);
  // R6
  stall_when_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> $stable(cnt_q));
  // R2
  push_grows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && !pop_o) |=> cnt_q == $past(cnt_q) + 1'b1);
  // R5
  pop_shrinks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_o && !push_o) |=> cnt_q == $past(cnt_q) - 1'b1);
  // R10
  both_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && pop_o) |=> $stable(cnt_q));
endmodule

// File: rtl/wb_store.sv
module wb_store #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int PW    = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      push_i,
  input  logic                      pop_i,
  input  logic [PW-1:0]             wr_ptr_i,
  input  logic [PW-1:0]             rd_ptr_i,
  input  logic [AW-1:0]             addr_i,
  input  logic [DW-1:0]             data_i,
  output logic [AW-1:0]             head_addr_o,
  output logic [DW-1:0]             head_data_o,
  output logic [DEPTH-1:0]          valid_o,
  output logic [DEPTH-1:0][AW-1:0]  slot_addr_o
);
  logic [DEPTH-1:0][AW-1:0] addr_q;
  logic [DEPTH-1:0][DW-1:0] data_q;
  logic [DEPTH-1:0]         vld_q;

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic wr_here, rd_here;
    assign wr_here = push_i && (wr_ptr_i == PW'(s));
    assign rd_here = pop_i  && (rd_ptr_i == PW'(s));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[s] <= 1'b0;
      end else if (wr_here) begin
        vld_q[s] <= 1'b1;
      end else if (rd_here) begin
        vld_q[s] <= 1'b0;
      end
    end

    always_ff @(posedge clk_i) begin
      if (wr_here) begin
        addr_q[s] <= addr_i;
        data_q[s] <= data_i;
      end
    end
  end

  assign head_addr_o = addr_q[rd_ptr_i];
  assign head_data_o = data_q[rd_ptr_i];
  assign valid_o     = vld_q;
  assign slot_addr_o = addr_q;

  // R7
  no_clobber_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (!vld_q[wr_ptr_i] || (pop_i && rd_ptr_i == wr_ptr_i)));
  // R5
  pop_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> vld_q[rd_ptr_i]);
endmodule

// File: rtl/wb_match.sv
module wb_match #(
  parameter int DEPTH = 8,
  parameter int AW    = 32
) (
  input  logic [DEPTH-1:0]         valid_i,
  input  logic [DEPTH-1:0][AW-1:0] slot_addr_i,
  input  logic [AW-1:0]            look_addr_i,
  output logic                     hit_o
);
  logic [DEPTH-1:0] eq;

  for (genvar s = 0; s < DEPTH; s++) begin : g_cmp
    assign eq[s] = valid_i[s] && (slot_addr_i[s] == look_addr_i);
  end

  assign hit_o = |eq;
endmodule

// File: rtl/post_wr_buf.sv
module post_wr_buf #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cpu_valid_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic [DW-1:0] cpu_data_i,
  output logic          cpu_stall_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_data_o,
  input  logic          mem_ack_i,
  input  logic [AW-1:0] look_addr_i,
  output logic          look_hit_o,
  output logic          empty_o,
  output logic [CW-1:0] count_o
);
  logic                     push, pop;
  logic [PW-1:0]            wr_ptr, rd_ptr;
  logic [DEPTH-1:0]         valid;
  logic [DEPTH-1:0][AW-1:0] slot_addr;

  wb_ctrl #(.DEPTH(DEPTH), .PW(PW), .CW(CW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cpu_valid_i (cpu_valid_i),
    .mem_ack_i   (mem_ack_i),
    .push_o      (push),
    .pop_o       (pop),
    .wr_ptr_o    (wr_ptr),
    .rd_ptr_o    (rd_ptr),
    .count_o     (count_o),
    .empty_o     (empty_o),
    .stall_o     (cpu_stall_o)
  );

  wb_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .PW(PW)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .pop_i       (pop),
    .wr_ptr_i    (wr_ptr),
    .rd_ptr_i    (rd_ptr),
    .addr_i      (cpu_addr_i),
    .data_i      (cpu_data_i),
    .head_addr_o (mem_addr_o),
    .head_data_o (mem_data_o),
    .valid_o     (valid),
    .slot_addr_o (slot_addr)
  );

  wb_match #(.DEPTH(DEPTH), .AW(AW)) u_match (
    .valid_i     (valid),
    .slot_addr_i (slot_addr),
    .look_addr_i (look_addr_i),
    .hit_o       (look_hit_o)
  );

  assign mem_req_o = !empty_o;

  // R4
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_data_o)));
  // R8
  hit_needs_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    look_hit_o |-> !empty_o);
  // R9
  valid_matches_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(valid) == int'(count_o));
endmodule

// File: tb/post_wr_buf_test.sv
module post_wr_buf_test;
  localparam int DEPTH = 8;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int CW = $clog2(DEPTH + 1);

  typedef struct packed {
    logic          v;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic          ack;
    logic [AW-1:0] la;
    logic          e_stall;
    logic          e_req;
    logic [AW-1:0] e_maddr;
    logic [DW-1:0] e_mdata;
    logic          e_hit;
    logic [CW-1:0] e_cnt;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 32'h10, 32'hD0, 1'b0, 32'h10, 1'b0, 1'b0, 32'h0,  32'h0,  1'b0, 4'd0},
    '{1'b1, 32'h14, 32'hD1, 1'b0, 32'h10, 1'b0, 1'b1, 32'h10, 32'hD0, 1'b1, 4'd1},
    '{1'b0, 32'h0,  32'h0,  1'b1, 32'h14, 1'b0, 1'b1, 32'h10, 32'hD0, 1'b1, 4'd2},
    '{1'b1, 32'h18, 32'hD2, 1'b1, 32'h10, 1'b0, 1'b1, 32'h14, 32'hD1, 1'b0, 4'd1},
    '{1'b0, 32'h0,  32'h0,  1'b0, 32'h18, 1'b0, 1'b1, 32'h18, 32'hD2, 1'b1, 4'd1},
    '{1'b0, 32'h0,  32'h0,  1'b1, 32'h18, 1'b0, 1'b1, 32'h18, 32'hD2, 1'b1, 4'd1},
    '{1'b0, 32'h0,  32'h0,  1'b0, 32'h18, 1'b0, 1'b0, 32'h0,  32'h0,  1'b0, 4'd0},
    '{1'b1, 32'h20, 32'hD3, 1'b0, 32'h20, 1'b0, 1'b0, 32'h0,  32'h0,  1'b0, 4'd0},
    '{1'b1, 32'h20, 32'hD4, 1'b0, 32'h20, 1'b0, 1'b1, 32'h20, 32'hD3, 1'b1, 4'd1},
    '{1'b0, 32'h0,  32'h0,  1'b1, 32'h20, 1'b0, 1'b1, 32'h20, 32'hD3, 1'b1, 4'd2},
    '{1'b0, 32'h0,  32'h0,  1'b1, 32'h20, 1'b0, 1'b1, 32'h20, 32'hD4, 1'b1, 4'd1},
    '{1'b0, 32'h0,  32'h0,  1'b0, 32'h20, 1'b0, 1'b0, 32'h0,  32'h0,  1'b0, 4'd0}
  };

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cpu_valid_i = 1'b0;
  logic [AW-1:0] cpu_addr_i = '0;
  logic [DW-1:0] cpu_data_i = '0;
  logic          mem_ack_i = 1'b0;
  logic [AW-1:0] look_addr_i = '0;
  logic          cpu_stall_o, mem_req_o, look_hit_o, empty_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_data_o;
  logic [CW-1:0] count_o;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  post_wr_buf #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cpu_valid_i(cpu_valid_i), .cpu_addr_i(cpu_addr_i), .cpu_data_i(cpu_data_i),
    .cpu_stall_o(cpu_stall_o),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o),
    .mem_ack_i(mem_ack_i),
    .look_addr_i(look_addr_i), .look_hit_o(look_hit_o),
    .empty_o(empty_o), .count_o(count_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive at the falling edge, settle, then sample before the rising edge
  task automatic drive(input logic v, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic ack, input logic [AW-1:0] la);
    @(negedge clk);
    cpu_valid_i = v; cpu_addr_i = a; cpu_data_i = d;
    mem_ack_i = ack; look_addr_i = la;
    #2;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    #5;
    // R1 reset state
    chk("R1 count", 32'(count_o), 0);
    chk("R1 empty", 32'(empty_o), 1);
    chk("R1 req", 32'(mem_req_o), 0);
    @(negedge clk); rst_ni = 1'b1;

    // table of vectors
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].v, VEC[i].a, VEC[i].d, VEC[i].ack, VEC[i].la);
      chk($sformatf("R2/R6 stall v%0d", i), 32'(cpu_stall_o), 32'(VEC[i].e_stall));
      chk($sformatf("R4 req v%0d", i), 32'(mem_req_o), 32'(VEC[i].e_req));
      if (VEC[i].e_req) begin
        chk($sformatf("R3 addr v%0d", i), mem_addr_o, VEC[i].e_maddr);
        chk($sformatf("R3 data v%0d", i), mem_data_o, VEC[i].e_mdata);
      end
      chk($sformatf("R8 hit v%0d", i), 32'(look_hit_o), 32'(VEC[i].e_hit));
      chk($sformatf("R9/R10 count v%0d", i), 32'(count_o), 32'(VEC[i].e_cnt));
      chk($sformatf("R9 empty v%0d", i), 32'(empty_o), 32'(VEC[i].e_cnt == 0));
    end

    // fill to depth without acknowledge
    for (int k = 0; k < DEPTH; k++) begin
      drive(1'b1, 32'h100 + 32'(k * 4), 32'hA000 + 32'(k), 1'b0, 32'h0);
      chk("R2 no stall while filling", 32'(cpu_stall_o), 0);
    end
    // full: stalled store must not enter (R6), head holds (R4)
    for (int k = 0; k < 3; k++) begin
      drive(1'b1, 32'h200, 32'hBEEF, 1'b0, 32'h200);
      chk("R6 stall when full", 32'(cpu_stall_o), 1);
      chk("R6 count at depth", 32'(count_o), DEPTH);
      chk("R8 stalled store not pending", 32'(look_hit_o), 0);
      chk("R4 head stable", mem_addr_o, 32'h100);
    end
    // R7 acknowledge and store in the same cycle at full
    drive(1'b1, 32'h200, 32'hBEEF, 1'b1, 32'h100);
    chk("R7 no stall with retire", 32'(cpu_stall_o), 0);
    chk("R8 hit on head", 32'(look_hit_o), 1);
    for (int k = 1; k < DEPTH; k++) begin
      drive(1'b0, 32'h0, 32'h0, 1'b1, 32'h100);
      if (k == 1) chk("R7 count stays at depth", 32'(count_o), DEPTH);
      if (k == 1) chk("R8 hit clears after retire", 32'(look_hit_o), 0);
      chk("R3 drain order addr", mem_addr_o, 32'h100 + 32'(k * 4));
      chk("R3 drain order data", mem_data_o, 32'hA000 + 32'(k));
    end
    drive(1'b0, 32'h0, 32'h0, 1'b1, 32'h200);
    chk("R3 last store addr", mem_addr_o, 32'h200);
    chk("R3 last store data", mem_data_o, 32'hBEEF);
    chk("R8 hit on last store", 32'(look_hit_o), 1);
    drive(1'b0, 32'h0, 32'h0, 1'b0, 32'h200);
    chk("R9 drained count", 32'(count_o), 0);
    chk("R9 drained empty", 32'(empty_o), 1);
    chk("R4 no req when empty", 32'(mem_req_o), 0);
    // R5 acknowledge with nothing held has no effect
    drive(1'b0, 32'h0, 32'h0, 1'b1, 32'h0);
    drive(1'b0, 32'h0, 32'h0, 1'b0, 32'h0);
    chk("R5 idle ack ignored", 32'(count_o), 0);

    // R1 reset in mid operation
    for (int k = 0; k < 3; k++) drive(1'b1, 32'h300 + 32'(k), 32'h1, 1'b0, 32'h0);
    drive(1'b0, 32'h0, 32'h0, 1'b0, 32'h300);
    chk("R9 count before reset", 32'(count_o), 3);
    rst_ni = 1'b0;
    #1;
    chk("R1 count after reset", 32'(count_o), 0);
    chk("R1 req after reset", 32'(mem_req_o), 0);
    chk("R1 hit after reset", 32'(look_hit_o), 0);
    @(negedge clk); rst_ni = 1'b1;

    done = 1'b1;
    finish_run();
  end
endmodule